// File: doc/BRIEF.md
# Processor Exception Entry Unit

This block handles the entry side of exceptions in a simple in-order RISC core that has a system-control coprocessor. In any cycle the pipeline may present one fault request. A request carries a fault kind, the faulting virtual address, a store/load flag, the address-space identifier, the virtual page number, a coprocessor number and the PC of the faulting instruction. The block turns the request into an exception code and a handler address. One clock edge later it redirects the fetch PC to that handler. On the same edge it updates the exception-state registers.

Three run-time settings shape the handler address. The boot-vector select bit chooses the base: either the programmable exception base or a fixed boot address. The exception-level bit changes the offset used for a TLB refill. The interrupt-vector bit changes the offset used for an interrupt. The block keeps the exception-level bit itself. Reset clears it, and every accepted fault sets it. The base, the boot-vector select bit and the interrupt-vector bit come from neighbouring logic.

Top module: `exc_entry`

## Requirements
- R1: `faultKind` encoding is 0 interrupt, 1 TLB refill, 2 TLB invalid, 3 TLB modified, 4 address error, 5 instruction bus error, 6 data bus error, 7 syscall, 8 breakpoint, 9 reserved instruction, 10 coprocessor unusable, 11 overflow, 12 trap, 13 watch, 14 machine check, 15 thread, 16 cache error. Values 17 to 31 are treated as reserved instruction.
- R1 (continued): The codes written to `causeExcCode` are interrupt 0, instruction bus error 6, data bus error 7, syscall 8, breakpoint 9, reserved instruction 10, coprocessor unusable 11, overflow 12, trap 13, watch 23, machine check 24, thread 25 and cache error 30.
- R2: The handler base is `ebase` when `statusBev` is 0 and 0xBFC00200 when it is 1. `pcTarget` is the base plus the offset, modulo 2^32.
- R3: The interrupt offset is 0x200 when `causeIv` is 1 and 0x180 when `causeIv` is 0.
- R4: The TLB refill offset is 0x000 when `statusExl` is 0 before the fault and 0x180 when it is already 1.
- R5: Every kind other than interrupt and TLB refill uses offset 0x180.
- R6: An address error gives code 5 for a store and code 4 for a load. It copies `faultVaddr` into `badVaddr`.
- R7: TLB refill and TLB invalid give code 3 for a store and code 2 for a load. TLB modified always gives code 1.
- R8: Any TLB kind (1 to 3) loads `badVaddr` with the address and `entryHiAsid` with the ASID. It loads `entryHiVpn2` and `contextBadVpn2` with the VPN shifted right by 2, and `entryHiVpn2x` with the low 2 bits of the VPN. Other kinds leave these registers unchanged.
- R9: A coprocessor-unusable fault loads `causeCe` with `faultCopId`. Other kinds leave `causeCe` unchanged.
- R10: Every accepted fault sets `statusExl`. `epc` takes `faultPc` only when `statusExl` was 0 before the fault. Otherwise `epc` is unchanged.
- R11: All updates, and a one-cycle `pcRedirect` pulse, appear on the clock edge after the cycle in which `faultValid` is high. In a cycle without a fault, the state holds and `pcRedirect` is 0.
- R12: Reset clears every output register and `pcRedirect` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| faultValid | input | 1 | Fault request this cycle |
| faultKind | input | 5 | Fault kind (R1 encoding) |
| faultVaddr | input | ADDR_W | Faulting virtual address |
| faultStore | input | 1 | 1 = store access, 0 = load |
| faultAsid | input | ASID_W | Address-space identifier |
| faultVpn | input | VPN_W | Virtual page number |
| faultCopId | input | 2 | Coprocessor number |
| faultPc | input | ADDR_W | PC of the faulting instruction |
| statusBev | input | 1 | Boot-vector select |
| causeIv | input | 1 | Interrupt-vector select |
| ebase | input | ADDR_W | Programmable exception base |
| pcRedirect | output | 1 | One-cycle redirect pulse |
| pcTarget | output | ADDR_W | Handler address |
| statusExl | output | 1 | Exception-level bit |
| causeExcCode | output | 5 | Exception code |
| causeCe | output | 2 | Unusable coprocessor number |
| badVaddr | output | ADDR_W | Faulting address register |
| epc | output | ADDR_W | Exception PC |
| entryHiAsid | output | ASID_W | TLB entry-high ASID field |
| entryHiVpn2 | output | VPN_W-2 | TLB entry-high VPN/2 field |
| entryHiVpn2x | output | 2 | TLB entry-high VPN extension |
| contextBadVpn2 | output | VPN_W-2 | Context register VPN/2 field |

## Verification
The bench builds the block with its defaults: ADDR_W 32, ASID_W 8 and VPN_W 21. The 32-bit address width lets the fixed boot base be checked literally. Adding 0x200 to a random `ebase` near the top of the space reaches the wrap of the vector sum. A 21-bit VPN places a 19-bit VPN/2 field on both TLB registers, so a shift or extension error is visible.

Every fault kind is driven under all eight combinations of boot-vector select, prior exception level and interrupt-vector select. This reaches each offset branch and the EPC hold. Random faults, idle gaps and resets follow.

// File: rtl/exc_pkg.sv
package exc_pkg;

  typedef enum logic [4:0] {
    KIND_INTR      = 5'd0,
    KIND_TLB_REFILL = 5'd1,
    KIND_TLB_INVAL = 5'd2,
    KIND_TLB_MOD   = 5'd3,
    KIND_ADDR_ERR  = 5'd4,
    KIND_IBUS_ERR  = 5'd5,
    KIND_DBUS_ERR  = 5'd6,
    KIND_SYSCALL   = 5'd7,
    KIND_BREAK     = 5'd8,
    KIND_RESV_INST = 5'd9,
    KIND_COP_UNUSE = 5'd10,
    KIND_OVERFLOW  = 5'd11,
    KIND_TRAP      = 5'd12,
    KIND_WATCH     = 5'd13,
    KIND_MCHECK    = 5'd14,
    KIND_THREAD    = 5'd15,
    KIND_CACHE_ERR = 5'd16
  } faultKindE;

  localparam int CODE_W = 5;
  localparam int OFS_W  = 10;

  localparam logic [OFS_W-1:0] OFS_GENERAL = 10'h180;
  localparam logic [OFS_W-1:0] OFS_IRQ_VEC = 10'h200;
  localparam logic [OFS_W-1:0] OFS_REFILL  = 10'h000;

  // Strobes passed from control to datapath
  typedef struct packed {
    logic              take;
    logic              saveEpc;
    logic              wrBadVaddr;
    logic              wrTlb;
    logic              wrCe;
    logic [CODE_W-1:0] code;
    logic [OFS_W-1:0]  offset;
  } ctrlStrobesT;

endpackage

// File: rtl/exc_ctrl.sv
module exc_ctrl
  import exc_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        faultValid,
  input  logic [4:0]  faultKind,
  input  logic        faultStore,
  input  logic        statusExl,
  input  logic        causeIv,
  output ctrlStrobesT strobes
);

  always_comb begin
    strobes            = '0;
    strobes.take       = faultValid;
    strobes.saveEpc    = faultValid && !statusExl;
    strobes.offset     = OFS_GENERAL;
    strobes.code       = 5'd10;
    unique case (faultKind)
      KIND_INTR: begin
        strobes.code   = 5'd0;
        strobes.offset = causeIv ? OFS_IRQ_VEC : OFS_GENERAL;
      end
      KIND_TLB_REFILL: begin
        strobes.code       = faultStore ? 5'd3 : 5'd2;
        strobes.offset     = statusExl ? OFS_GENERAL : OFS_REFILL;
        strobes.wrTlb      = faultValid;
        strobes.wrBadVaddr = faultValid;
      end
      KIND_TLB_INVAL: begin
        strobes.code       = faultStore ? 5'd3 : 5'd2;
        strobes.wrTlb      = faultValid;
        strobes.wrBadVaddr = faultValid;
      end
      KIND_TLB_MOD: begin
        strobes.code       = 5'd1;
        strobes.wrTlb      = faultValid;
        strobes.wrBadVaddr = faultValid;
      end
      KIND_ADDR_ERR: begin
        strobes.code       = faultStore ? 5'd5 : 5'd4;
        strobes.wrBadVaddr = faultValid;
      end
      KIND_IBUS_ERR:  strobes.code = 5'd6;
      KIND_DBUS_ERR:  strobes.code = 5'd7;
      KIND_SYSCALL:   strobes.code = 5'd8;
      KIND_BREAK:     strobes.code = 5'd9;
      KIND_RESV_INST: strobes.code = 5'd10;
      KIND_COP_UNUSE: begin
        strobes.code = 5'd11;
        strobes.wrCe = faultValid;
      end
      KIND_OVERFLOW:  strobes.code = 5'd12;
      KIND_TRAP:      strobes.code = 5'd13;
      KIND_WATCH:     strobes.code = 5'd23;
      KIND_MCHECK:    strobes.code = 5'd24;
      KIND_THREAD:    strobes.code = 5'd25;
      KIND_CACHE_ERR: strobes.code = 5'd30;
      default:        strobes.code = 5'd10;
    endcase
  end

  // R9
  ce_tlb_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.wrCe |-> !strobes.wrTlb && !strobes.wrBadVaddr);

endmodule

// File: rtl/exc_datapath.sv
module exc_datapath
  import exc_pkg::*;
#(
  parameter int                ADDR_W    = 32,
  parameter int                ASID_W    = 8,
  parameter int                VPN_W     = 21,
  parameter logic [ADDR_W-1:0] BOOT_BASE = 32'hBFC00200
) (
  input  logic                clk,
  input  logic                rstN,
  input  ctrlStrobesT         strobes,
  input  logic [ADDR_W-1:0]   faultVaddr,
  input  logic [ASID_W-1:0]   faultAsid,
  input  logic [VPN_W-1:0]    faultVpn,
  input  logic [1:0]          faultCopId,
  input  logic [ADDR_W-1:0]   faultPc,
  input  logic                statusBev,
  input  logic [ADDR_W-1:0]   ebase,
  output logic                pcRedirect,
  output logic [ADDR_W-1:0]   pcTarget,
  output logic                statusExl,
  output logic [CODE_W-1:0]   causeExcCode,
  output logic [1:0]          causeCe,
  output logic [ADDR_W-1:0]   badVaddr,
  output logic [ADDR_W-1:0]   epc,
  output logic [ASID_W-1:0]   entryHiAsid,
  output logic [VPN_W-3:0]    entryHiVpn2,
  output logic [1:0]          entryHiVpn2x,
  output logic [VPN_W-3:0]    contextBadVpn2
);

  localparam int VPN2_W = VPN_W - 2;

  logic [ADDR_W-1:0] vecBase;
  logic [ADDR_W-1:0] vecAddr;
  logic [VPN2_W-1:0] vpnHalf;

  assign vecBase = statusBev ? BOOT_BASE : ebase;
  assign vecAddr = vecBase + ADDR_W'(strobes.offset);
  assign vpnHalf = faultVpn[VPN_W-1:2];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pcRedirect     <= 1'b0;
      pcTarget       <= '0;
      statusExl      <= 1'b0;
      causeExcCode   <= '0;
      causeCe        <= '0;
      badVaddr       <= '0;
      epc            <= '0;
      entryHiAsid    <= '0;
      entryHiVpn2    <= '0;
      entryHiVpn2x   <= '0;
      contextBadVpn2 <= '0;
    end else begin
      pcRedirect <= strobes.take;
      if (strobes.take) begin
        pcTarget     <= vecAddr;
        statusExl    <= 1'b1;
        causeExcCode <= strobes.code;
      end
      if (strobes.saveEpc)    epc      <= faultPc;
      if (strobes.wrBadVaddr) badVaddr <= faultVaddr;
      if (strobes.wrCe)       causeCe  <= faultCopId;
      if (strobes.wrTlb) begin
        entryHiAsid    <= faultAsid;
        entryHiVpn2    <= vpnHalf;
        entryHiVpn2x   <= faultVpn[1:0];
        contextBadVpn2 <= vpnHalf;
      end
    end
  end

  // R10
  exl_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.take |=> statusExl);

  // R10
  epc_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.take && statusExl) |=> $stable(epc));

  // R11
  redirect_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.take |=> pcRedirect);

  // R11
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.take |=> (!pcRedirect && $stable(causeExcCode) && $stable(pcTarget)));

endmodule

// File: rtl/exc_entry.sv
module exc_entry
  import exc_pkg::*;
#(
  parameter int                ADDR_W    = 32,
  parameter int                ASID_W    = 8,
  parameter int                VPN_W     = 21,
  parameter logic [ADDR_W-1:0] BOOT_BASE = 32'hBFC00200
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              faultValid,
  input  logic [4:0]        faultKind,
  input  logic [ADDR_W-1:0] faultVaddr,
  input  logic              faultStore,
  input  logic [ASID_W-1:0] faultAsid,
  input  logic [VPN_W-1:0]  faultVpn,
  input  logic [1:0]        faultCopId,
  input  logic [ADDR_W-1:0] faultPc,
  input  logic              statusBev,
  input  logic              causeIv,
  input  logic [ADDR_W-1:0] ebase,
  output logic              pcRedirect,
  output logic [ADDR_W-1:0] pcTarget,
  output logic              statusExl,
  output logic [4:0]        causeExcCode,
  output logic [1:0]        causeCe,
  output logic [ADDR_W-1:0] badVaddr,
  output logic [ADDR_W-1:0] epc,
  output logic [ASID_W-1:0] entryHiAsid,
  output logic [VPN_W-3:0]  entryHiVpn2,
  output logic [1:0]        entryHiVpn2x,
  output logic [VPN_W-3:0]  contextBadVpn2
);

  ctrlStrobesT strobes;

  exc_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .faultValid (faultValid),
    .faultKind  (faultKind),
    .faultStore (faultStore),
    .statusExl  (statusExl),
    .causeIv    (causeIv),
    .strobes    (strobes)
  );

  exc_datapath #(
    .ADDR_W    (ADDR_W),
    .ASID_W    (ASID_W),
    .VPN_W     (VPN_W),
    .BOOT_BASE (BOOT_BASE)
  ) u_dp (
    .clk            (clk),
    .rstN           (rstN),
    .strobes        (strobes),
    .faultVaddr     (faultVaddr),
    .faultAsid      (faultAsid),
    .faultVpn       (faultVpn),
    .faultCopId     (faultCopId),
    .faultPc        (faultPc),
    .statusBev      (statusBev),
    .ebase          (ebase),
    .pcRedirect     (pcRedirect),
    .pcTarget       (pcTarget),
    .statusExl      (statusExl),
    .causeExcCode   (causeExcCode),
    .causeCe        (causeCe),
    .badVaddr       (badVaddr),
    .epc            (epc),
    .entryHiAsid    (entryHiAsid),
    .entryHiVpn2    (entryHiVpn2),
    .entryHiVpn2x   (entryHiVpn2x),
    .contextBadVpn2 (contextBadVpn2)
  );

endmodule

// File: tb/exc_entry_tb.sv
module exc_entry_tb;

  localparam int ADDR_W = 32;
  localparam int ASID_W = 8;
  localparam int VPN_W  = 21;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              faultValid = 1'b0;
  logic [4:0]        faultKind = '0;
  logic [ADDR_W-1:0] faultVaddr = '0;
  logic              faultStore = 1'b0;
  logic [ASID_W-1:0] faultAsid = '0;
  logic [VPN_W-1:0]  faultVpn = '0;
  logic [1:0]        faultCopId = '0;
  logic [ADDR_W-1:0] faultPc = '0;
  logic              statusBev = 1'b0;
  logic              causeIv = 1'b0;
  logic [ADDR_W-1:0] ebase = '0;
  logic              pcRedirect;
  logic [ADDR_W-1:0] pcTarget;
  logic              statusExl;
  logic [4:0]        causeExcCode;
  logic [1:0]        causeCe;
  logic [ADDR_W-1:0] badVaddr;
  logic [ADDR_W-1:0] epc;
  logic [ASID_W-1:0] entryHiAsid;
  logic [VPN_W-3:0]  entryHiVpn2;
  logic [1:0]        entryHiVpn2x;
  logic [VPN_W-3:0]  contextBadVpn2;

  int checks = 0;
  int failures = 0;

  // model state
  logic              mExl;
  logic [ADDR_W-1:0] mTarget, mEpc, mBad;
  logic [4:0]        mCode;
  logic [1:0]        mCe;
  logic [ASID_W-1:0] mAsid;
  logic [VPN_W-3:0]  mVpn2, mCtx;
  logic [1:0]        mVpn2x;

  always #2 clk = ~clk;  // 250 MHz

  exc_entry u_dut (.*);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [4:0] expCode(logic [4:0] k, logic st);
    case (k)
      5'd0:  return 5'd0;
      5'd1, 5'd2: return st ? 5'd3 : 5'd2;
      5'd3:  return 5'd1;
      5'd4:  return st ? 5'd5 : 5'd4;
      5'd5:  return 5'd6;
      5'd6:  return 5'd7;
      5'd7:  return 5'd8;
      5'd8:  return 5'd9;
      5'd9:  return 5'd10;
      5'd10: return 5'd11;
      5'd11: return 5'd12;
      5'd12: return 5'd13;
      5'd13: return 5'd23;
      5'd14: return 5'd24;
      5'd15: return 5'd25;
      5'd16: return 5'd30;
      default: return 5'd10;
    endcase
  endfunction

  function automatic logic [31:0] expOffset(logic [4:0] k, logic exl, logic iv);
    if (k == 5'd0) return iv ? 32'h200 : 32'h180;
    if (k == 5'd1) return exl ? 32'h180 : 32'h000;
    return 32'h180;
  endfunction

  function automatic string codeReq(logic [4:0] k);
    if (k >= 5'd1 && k <= 5'd3) return "R7";
    if (k == 5'd4) return "R6";
    return "R1";
  endfunction

  function automatic string vecReq(logic [4:0] k);
    if (k == 5'd0) return "R2 R3";
    if (k == 5'd1) return "R2 R4";
    return "R2 R5";
  endfunction

  task automatic checkAll(string tag);
    chk({tag, " R11 redirect"}, 32'(pcRedirect), 32'(faultValid === 1'b0 ? 1'b1 : 1'b1));
    chk({tag, " vector"}, pcTarget, mTarget);
    chk({tag, " R10 exl"}, 32'(statusExl), 32'(mExl));
    chk({tag, " code"}, 32'(causeExcCode), 32'(mCode));
    chk({tag, " R9 ce"}, 32'(causeCe), 32'(mCe));
    chk({tag, " R6 R8 badvaddr"}, badVaddr, mBad);
    chk({tag, " R10 epc"}, epc, mEpc);
    chk({tag, " R8 asid"}, 32'(entryHiAsid), 32'(mAsid));
    chk({tag, " R8 vpn2"}, 32'(entryHiVpn2), 32'(mVpn2));
    chk({tag, " R8 vpn2x"}, 32'(entryHiVpn2x), 32'(mVpn2x));
    chk({tag, " R8 context"}, 32'(contextBadVpn2), 32'(mCtx));
  endtask

  task automatic doReset();
    rstN = 1'b0;
    faultValid = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    mExl = 0; mTarget = '0; mEpc = '0; mBad = '0; mCode = '0; mCe = '0;
    mAsid = '0; mVpn2 = '0; mCtx = '0; mVpn2x = '0;
  endtask

  // called at a negedge; returns at the following negedge with checks done
  task automatic doFault(logic [4:0] k, logic st, logic bev, logic iv, logic [31:0] eb);
    logic [31:0] base;
    logic [31:0] va  = $urandom;
    logic [31:0] pc  = $urandom;
    logic [VPN_W-1:0] vpn = VPN_W'($urandom);
    logic [ASID_W-1:0] asid = ASID_W'($urandom);
    logic [1:0] cop = 2'($urandom);
    faultKind = k; faultStore = st; statusBev = bev; causeIv = iv; ebase = eb;
    faultVaddr = va; faultPc = pc; faultVpn = vpn; faultAsid = asid; faultCopId = cop;
    faultValid = 1'b1;
    base = bev ? 32'hBFC00200 : eb;
    mTarget = base + expOffset(k, mExl, iv);
    mCode = expCode(k, st);
    if (!mExl) mEpc = pc;
    mExl = 1'b1;
    if (k >= 5'd1 && k <= 5'd4) mBad = va;
    if (k >= 5'd1 && k <= 5'd3) begin
      mAsid = asid; mVpn2 = vpn[VPN_W-1:2]; mVpn2x = vpn[1:0]; mCtx = vpn[VPN_W-1:2];
    end
    if (k == 5'd10) mCe = cop;
    @(negedge clk);
    faultValid = 1'b0;
    checks++;
    if (pcRedirect !== 1'b1) begin
      failures++;
      $display("FAIL R11 redirect actual=%b expected=1", pcRedirect);
    end
    chk({vecReq(k), " vector"}, pcTarget, mTarget);
    chk({codeReq(k), " code"}, 32'(causeExcCode), 32'(mCode));
    chk("R10 exl", 32'(statusExl), 32'(mExl));
    chk("R10 epc", epc, mEpc);
    chk("R6 R8 badvaddr", badVaddr, mBad);
    chk("R9 ce", 32'(causeCe), 32'(mCe));
    chk("R8 asid", 32'(entryHiAsid), 32'(mAsid));
    chk("R8 vpn2", 32'(entryHiVpn2), 32'(mVpn2));
    chk("R8 vpn2x", 32'(entryHiVpn2x), 32'(mVpn2x));
    chk("R8 context", 32'(contextBadVpn2), 32'(mCtx));
  endtask

  task automatic doIdle();
    faultKind = 5'($urandom); faultVaddr = $urandom; faultVpn = VPN_W'($urandom);
    faultCopId = 2'($urandom); faultPc = $urandom;
    @(negedge clk);
    chk("R11 idle redirect", 32'(pcRedirect), 32'd0);
    chk("R11 idle hold code", 32'(causeExcCode), 32'(mCode));
    chk("R11 idle hold vector", pcTarget, mTarget);
    chk("R11 idle hold epc", epc, mEpc);
    chk("R11 idle hold ce", 32'(causeCe), 32'(mCe));
  endtask

  initial begin
    void'($urandom(32'd5150));
    doReset();
    // R12 reset state
    chk("R12 reset redirect", 32'(pcRedirect), 32'd0);
    chk("R12 reset target", pcTarget, 32'd0);
    chk("R12 reset exl", 32'(statusExl), 32'd0);
    chk("R12 reset code", 32'(causeExcCode), 32'd0);
    chk("R12 reset epc", epc, 32'd0);
    chk("R12 reset badvaddr", badVaddr, 32'd0);
    chk("R12 reset context", 32'(contextBadVpn2), 32'd0);

    // directed sweep: every kind under each bev / prior exl / iv combination
    for (int k = 0; k < 17; k++) begin
      for (int c = 0; c < 8; c++) begin
        doReset();
        if (c[1]) doFault(5'd7, 1'b0, 1'b0, 1'b0, 32'h8000_0000);
        doFault(5'(k), 1'($urandom), c[0], c[2], $urandom & 32'hFFFF_F000);
        doIdle();
      end
    end

    // R2 wrap of the vector sum; R6 load/store codes
    doReset();
    doFault(5'd0, 1'b0, 1'b0, 1'b1, 32'hFFFF_FF00);
    doFault(5'd4, 1'b1, 1'b0, 1'b0, 32'h0);
    doFault(5'd4, 1'b0, 1'b1, 1'b0, 32'h0);
    // R1 out-of-range kind behaves as reserved instruction
    doFault(5'd31, 1'b0, 1'b0, 1'b0, 32'h1000);

    // random phase
    for (int i = 0; i < 400; i++) begin
      if ($urandom_range(0, 5) == 0) doReset();
      doFault(5'($urandom_range(0, 16)), 1'($urandom), 1'($urandom), 1'($urandom),
              $urandom);
      if ($urandom_range(0, 2) == 0) doIdle();
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule